// File: doc/BRIEF.md
# Debug-Triggered Full-Device Wipe Sequencer

This block lets an external debug host return a device to a blank state. The host writes a trigger bit through a small register window. The sequencer then asks three memory controllers, one after another, to erase their contents: program flash first, then SRAM, then the configuration area. Each request is a level held high until the controller answers with a one-cycle done pulse. With the dual-core option, the three phases run for the primary application core and then again for the secondary core.

A protection setting is captured whenever the debug-domain reset is applied. While that setting is active, wipe requests are ignored. Once a wipe has been accepted, the soft-reset request bit is forced low and can no longer be written until the next debug-domain reset. When a wipe completes, the block only records that fact. The access-unlock output rises at the following debug-domain reset and stays high until a cold reset.

There are two resets, both synchronous and active low. `por_n` is the cold reset and clears everything. `rst_n` is the debug-domain (warm) reset. It re-samples the protection input and turns a recorded completion into the unlock output.

Top module: `wipe_sequencer`

## Requirements
- R1: Writing a value with bit 0 set to offset 0x04 starts a wipe when the block is idle and unprotected, and `phase_req_o` shows the flash request (bit 0) on the next cycle. A write with bit 0 clear has no effect.
- R2: Bit 0 at offset 0x08 reads 1 from the cycle after the wipe is accepted until the last configuration-area done pulse is taken, and reads 0 at all other times; a wipe with per-phase wait d occupies d+1 cycles per phase.
- R3: The phases are flash (`phase_req_o` bit 0), then SRAM (bit 1), then configuration area (bit 2). At most one request is high at a time. Each request is held until its own done lane pulses; a done pulse on any other lane is ignored.
- R4: Offset 0x00 bit 0 is read/write. Writing 1 drives `soft_reset_o` high, writing 0 drives it low, and a read returns its current value.
- R5: From the accepted wipe onward, the soft-reset bit reads 0 and writes to it are ignored until `rst_n` or `por_n` is applied.
- R6: `prot_cfg_i` is sampled during reset (1 means protected). While the sampled value is 1, triggers are ignored. Offset 0x18 bit 0 reads 0 when protected and 1 when unprotected, and a later change of `prot_cfg_i` has no effect until the next reset.
- R7: `ap_open_o` stays low when a wipe completes. It rises at the next `rst_n` reset after completion, stays high across further warm resets, and clears only on `por_n`.
- R8: With the dual-core option, all three phases run with `core_sel_o` = 0 (primary core) before the three phases run with `core_sel_o` = 1.
- R9: A trigger written while a wipe is in progress is ignored; the running phase and core are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Cold reset, synchronous, active low |
| rst_n | input | 1 | Debug-domain reset, synchronous, active low |
| prot_cfg_i | input | 1 | Erase-protection setting, sampled during reset (1 = protected) |
| dbg_sel_i | input | 1 | Register access select |
| dbg_wr_i | input | 1 | 1 = write, 0 = read |
| dbg_addr_i | input | AW (8) | Byte offset of the register |
| dbg_wdata_i | input | DW (32) | Write data |
| dbg_rdata_o | output | DW (32) | Read data, combinational from the selected offset |
| phase_req_o | output | 3 | Erase requests: bit 0 flash, bit 1 SRAM, bit 2 configuration area |
| phase_done_i | input | 3 | One-cycle done pulses, one lane per request bit |
| core_sel_o | output | 1 | Core being wiped: 0 primary, 1 secondary |
| soft_reset_o | output | 1 | Soft-reset request level |
| ap_open_o | output | 1 | Access protection cleared (after a reset following a completed wipe) |

## Verification
The assertions assume that the memory controllers answer only while their request is high, and only with single-cycle done pulses. They also assume that both resets are applied at time zero before any register access. The bench respects these assumptions: its stub raises a done lane for exactly one cycle, only after the matching request has been observed. The one exception is a deliberate wrong-lane pulse, which is sent while a different request is active so that R3 can be checked. Every stimulus starts with a combined cold and warm reset. The wait sweep then covers all 27 combinations of 0 to 2 idle cycles per phase, and the expected busy length is computed arithmetically from those waits.

// File: rtl/wipe_pkg.sv
package wipe_pkg;
    localparam int NUM_PHASES = 3;

    localparam logic [7:0] OFS_SOFTRST  = 8'h00;
    localparam logic [7:0] OFS_TRIGGER  = 8'h04;
    localparam logic [7:0] OFS_BUSY     = 8'h08;
    localparam logic [7:0] OFS_PROTSTAT = 8'h18;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_FLASH = 2'd1,
        PH_SRAM  = 2'd2,
        PH_CONF  = 2'd3
    } phase_e;

    typedef struct packed {
        phase_e phase;
        logic   core;
    } eng_s;

    typedef struct packed {
        logic soft_rst;
        logic freeze;
        logic protect;
        logic mark;
        logic ap_open;
    } guard_s;
endpackage

// File: rtl/wipe_decode.sv
module wipe_decode
    import wipe_pkg::*;
#(
    parameter int AW = 8,
    parameter int DW = 32
) (
    input  logic          sel_i,
    input  logic          wr_i,
    input  logic [AW-1:0] addr_i,
    input  logic [DW-1:0] wdata_i,
    input  logic          soft_rst_i,
    input  logic          busy_i,
    input  logic          protect_i,
    output logic [DW-1:0] rdata_o,
    output logic          wr_softrst_o,
    output logic          softrst_val_o,
    output logic          wr_trigger_o
);
    logic [DW-2:0] unused_wdata;
    assign unused_wdata = wdata_i[DW-1:1];

    always_comb begin
        wr_softrst_o  = sel_i && wr_i && (addr_i == AW'(OFS_SOFTRST));
        softrst_val_o = wdata_i[0];
        wr_trigger_o  = sel_i && wr_i && (addr_i == AW'(OFS_TRIGGER)) && wdata_i[0];
    end

    always_comb begin
        rdata_o = '0;
        if (sel_i && !wr_i) begin
            if (addr_i == AW'(OFS_SOFTRST))  rdata_o = DW'(soft_rst_i);
            if (addr_i == AW'(OFS_BUSY))     rdata_o = DW'(busy_i);
            if (addr_i == AW'(OFS_PROTSTAT)) rdata_o = DW'(!protect_i);
        end
    end
endmodule

// File: rtl/wipe_guard.sv
module wipe_guard
    import wipe_pkg::*;
(
    input  logic clk,
    input  logic por_n,
    input  logic rst_n,
    input  logic prot_cfg_i,
    input  logic wr_softrst_i,
    input  logic softrst_val_i,
    input  logic wr_trigger_i,
    input  logic busy_i,
    input  logic finish_i,
    output logic start_o,
    output logic soft_rst_o,
    output logic protect_o,
    output logic ap_open_o
);
    guard_s q, d;

    always_comb begin
        d       = q;
        start_o = wr_trigger_i && !busy_i && !q.protect;
        if (start_o) d.freeze = 1'b1;
        if (start_o || q.freeze)  d.soft_rst = 1'b0;
        else if (wr_softrst_i)    d.soft_rst = softrst_val_i;
        if (finish_i) d.mark = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!por_n) begin
            q         <= '0;
            q.protect <= prot_cfg_i;
        end else if (!rst_n) begin
            q.soft_rst <= 1'b0;
            q.freeze   <= 1'b0;
            q.protect  <= prot_cfg_i;
            q.mark     <= 1'b0;
            q.ap_open  <= q.ap_open | q.mark;
        end else begin
            q <= d;
        end
    end

    assign soft_rst_o = q.soft_rst;
    assign protect_o  = q.protect;
    assign ap_open_o  = q.ap_open;
endmodule

// File: rtl/wipe_engine.sv
module wipe_engine
    import wipe_pkg::*;
#(
    parameter bit DUAL_CORE = 1'b1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start_i,
    input  logic [NUM_PHASES-1:0] done_i,
    output logic [NUM_PHASES-1:0] req_o,
    output logic                  core_o,
    output logic                  busy_o,
    output logic                  finish_o
);
    localparam logic LAST_CORE = DUAL_CORE ? 1'b1 : 1'b0;

    eng_s q, d;

    always_comb begin
        d        = q;
        finish_o = 1'b0;
        unique case (q.phase)
            PH_IDLE: if (start_i) begin
                d.phase = PH_FLASH;
                d.core  = 1'b0;
            end
            PH_FLASH: if (done_i[0]) d.phase = PH_SRAM;
            PH_SRAM:  if (done_i[1]) d.phase = PH_CONF;
            PH_CONF: if (done_i[2]) begin
                if (q.core != LAST_CORE) begin
                    d.phase = PH_FLASH;
                    d.core  = 1'b1;
                end else begin
                    d.phase  = PH_IDLE;
                    finish_o = 1'b1;
                end
            end
            default: d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '{phase: PH_IDLE, core: 1'b0};
        else        q <= d;
    end

    for (genvar g = 0; g < NUM_PHASES; g++) begin : g_req
        assign req_o[g] = (q.phase == phase_e'(2'(g + 1)));
    end

    assign core_o = q.core;
    assign busy_o = (q.phase != PH_IDLE);
endmodule

// File: rtl/wipe_sequencer.sv
module wipe_sequencer
    import wipe_pkg::*;
#(
    parameter int AW        = 8,
    parameter int DW        = 32,
    parameter bit DUAL_CORE = 1'b1
) (
    input  logic                  clk,
    input  logic                  por_n,
    input  logic                  rst_n,
    input  logic                  prot_cfg_i,
    input  logic                  dbg_sel_i,
    input  logic                  dbg_wr_i,
    input  logic [AW-1:0]         dbg_addr_i,
    input  logic [DW-1:0]         dbg_wdata_i,
    output logic [DW-1:0]         dbg_rdata_o,
    output logic [NUM_PHASES-1:0] phase_req_o,
    input  logic [NUM_PHASES-1:0] phase_done_i,
    output logic                  core_sel_o,
    output logic                  soft_reset_o,
    output logic                  ap_open_o
);
    logic busy_w, protect_w, start_w, finish_w;
    logic wr_softrst_w, softrst_val_w, wr_trigger_w;
    logic rst_all_n;

    assign rst_all_n = por_n && rst_n;

    wipe_decode #(.AW(AW), .DW(DW)) u_decode (
        .sel_i         (dbg_sel_i),
        .wr_i          (dbg_wr_i),
        .addr_i        (dbg_addr_i),
        .wdata_i       (dbg_wdata_i),
        .soft_rst_i    (soft_reset_o),
        .busy_i        (busy_w),
        .protect_i     (protect_w),
        .rdata_o       (dbg_rdata_o),
        .wr_softrst_o  (wr_softrst_w),
        .softrst_val_o (softrst_val_w),
        .wr_trigger_o  (wr_trigger_w)
    );

    wipe_guard u_guard (
        .clk           (clk),
        .por_n         (por_n),
        .rst_n         (rst_n),
        .prot_cfg_i    (prot_cfg_i),
        .wr_softrst_i  (wr_softrst_w),
        .softrst_val_i (softrst_val_w),
        .wr_trigger_i  (wr_trigger_w),
        .busy_i        (busy_w),
        .finish_i      (finish_w),
        .start_o       (start_w),
        .soft_rst_o    (soft_reset_o),
        .protect_o     (protect_w),
        .ap_open_o     (ap_open_o)
    );

    wipe_engine #(.DUAL_CORE(DUAL_CORE)) u_engine (
        .clk      (clk),
        .rst_n    (rst_all_n),
        .start_i  (start_w),
        .done_i   (phase_done_i),
        .req_o    (phase_req_o),
        .core_o   (core_sel_o),
        .busy_o   (busy_w),
        .finish_o (finish_w)
    );
endmodule

// File: rtl/wipe_checker.sv
module wipe_checker (
    input logic       clk,
    input logic       por_n,
    input logic       rst_n,
    input logic       busy_i,
    input logic       protect_i,
    input logic [2:0] phase_req_i,
    input logic [2:0] phase_done_i,
    input logic       core_sel_i,
    input logic       soft_reset_i,
    input logic       ap_open_i
);
    assert_req_onehot_R3: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
        $onehot0(phase_req_i));

    assert_flash_then_sram_R3: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
        (phase_req_i == 3'b001 && phase_done_i[0]) |=> (phase_req_i == 3'b010));

    assert_start_primary_flash_R8: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
        $rose(busy_i) |-> (phase_req_i == 3'b001 && !core_sel_i));

    assert_busy_busy_tracks_req_R2: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
        $fell(busy_i) |-> $past(phase_req_i[2] && phase_done_i[2]));

    assert_softrst_low_in_wipe_R5: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
        busy_i |-> !soft_reset_i);

    assert_protected_never_busy_R6: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
        protect_i |-> !busy_i);

    assert_unlock_only_at_reset_R7: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
        $past(rst_n) |-> $stable(ap_open_i));
endmodule

bind wipe_sequencer wipe_checker u_chk (
    .clk          (clk),
    .por_n        (por_n),
    .rst_n        (rst_n),
    .busy_i       (busy_w),
    .protect_i    (protect_w),
    .phase_req_i  (phase_req_o),
    .phase_done_i (phase_done_i),
    .core_sel_i   (core_sel_o),
    .soft_reset_i (soft_reset_o),
    .ap_open_i    (ap_open_o)
);

// File: tb/wipe_sequencer_test.sv
module wipe_sequencer_test;
    logic        clk = 1'b0;
    logic        por_n = 1'b0, rst_n = 1'b0, prot_cfg = 1'b0;
    logic        sel = 1'b0, wr = 1'b0;
    logic [7:0]  addr = '0;
    logic [31:0] wdata = '0, rdata;
    logic [2:0]  req, done = '0;
    logic        core, srst, apo;
    int          checks = 0, fails = 0, busy_cnt = 0;
    bit          finished = 1'b0;

    always #2.5 clk = ~clk;

    wipe_sequencer uut (
        .clk(clk), .por_n(por_n), .rst_n(rst_n), .prot_cfg_i(prot_cfg),
        .dbg_sel_i(sel), .dbg_wr_i(wr), .dbg_addr_i(addr), .dbg_wdata_i(wdata),
        .dbg_rdata_o(rdata), .phase_req_o(req), .phase_done_i(done),
        .core_sel_o(core), .soft_reset_o(srst), .ap_open_o(apo)
    );

    always @(negedge clk) if (req != 3'b000) busy_cnt++;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wreg(input logic [7:0] a, input logic [31:0] v);
        @(negedge clk); sel = 1'b1; wr = 1'b1; addr = a; wdata = v;
        @(negedge clk); sel = 1'b0; wr = 1'b0;
    endtask

    task automatic rreg(input logic [7:0] a, output logic [31:0] v);
        sel = 1'b1; wr = 1'b0; addr = a;
        #0.5 v = rdata;
        sel = 1'b0;
    endtask

    task automatic step(input logic [2:0] exp, input logic ec, input int d);
        check("R3 phase request", 32'(req), 32'(exp));
        check("R8 core select", 32'(core), 32'(ec));
        repeat (d) @(negedge clk);
        done = exp;
        @(negedge clk);
        done = 3'b000;
    endtask

    task automatic warm_reset();
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
    endtask

    initial begin
        #1_000_000;
        if (!finished) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        int c0;
        repeat (3) @(negedge clk);
        por_n = 1'b1; rst_n = 1'b1;
        #0.5;
        check("R2 reset idle", 32'(req), 0);
        check("R4 reset soft reset", 32'(srst), 0);
        check("R7 reset unlock", 32'(apo), 0);
        rreg(8'h08, v); check("R2 status idle", v, 0);
        rreg(8'h18, v); check("R6 unprotected status", v, 1);

        // R4 soft reset read/write
        wreg(8'h00, 32'h1);
        check("R4 soft reset set", 32'(srst), 1);
        rreg(8'h00, v); check("R4 soft reset readback", v, 1);
        wreg(8'h00, 32'h0);
        check("R4 soft reset clear", 32'(srst), 0);
        wreg(8'h00, 32'h1);

        // R1 write 0 to trigger has no effect
        wreg(8'h04, 32'h0);
        check("R1 zero write no start", 32'(req), 0);
        rreg(8'h08, v); check("R1 status after zero write", v, 0);

        // R1 start, R3 wrong lane, R5 freeze
        wreg(8'h04, 32'h1);
        check("R1 flash requested", 32'(req), 32'h1);
        check("R5 soft reset forced low", 32'(srst), 0);
        rreg(8'h08, v); check("R2 status busy", v, 1);
        done = 3'b010; @(negedge clk); done = 3'b000;
        check("R3 wrong lane ignored", 32'(req), 32'h1);
        wreg(8'h00, 32'h1);
        rreg(8'h00, v); check("R5 soft reset write ignored", v, 0);
        step(3'b001, 1'b0, 0); step(3'b010, 1'b0, 1); step(3'b100, 1'b0, 0);
        step(3'b001, 1'b1, 0); step(3'b010, 1'b1, 0); step(3'b100, 1'b1, 2);
        rreg(8'h08, v); check("R2 ready after wipe", v, 0);
        check("R7 no unlock at completion", 32'(apo), 0);

        // R2 R3 R8 sweep of per-phase waits
        for (int d0 = 0; d0 < 3; d0++)
            for (int d1 = 0; d1 < 3; d1++)
                for (int d2 = 0; d2 < 3; d2++) begin
                    #0.5 c0 = busy_cnt;
                    wreg(8'h04, 32'h1);
                    for (int c = 0; c < 2; c++) begin
                        step(3'b001, c[0], d0);
                        step(3'b010, c[0], d1);
                        step(3'b100, c[0], d2);
                    end
                    #0.5;
                    check("R2 busy length", 32'(busy_cnt - c0), 32'(2 * (d0 + d1 + d2 + 3)));
                    rreg(8'h08, v); check("R2 ready after sweep run", v, 0);
                end

        // R9 trigger while busy
        wreg(8'h04, 32'h1);
        step(3'b001, 1'b0, 0);
        wreg(8'h04, 32'h1);
        check("R9 retrigger keeps sram", 32'(req), 32'h2);
        check("R9 retrigger keeps core", 32'(core), 0);
        step(3'b010, 1'b0, 0); step(3'b100, 1'b0, 0);
        step(3'b001, 1'b1, 0); step(3'b010, 1'b1, 0); step(3'b100, 1'b1, 0);
        check("R9 done after retrigger run", 32'(req), 0);

        // R7 unlock at next warm reset; R5 soft reset free again
        check("R7 still locked before reset", 32'(apo), 0);
        warm_reset();
        check("R7 unlock after reset", 32'(apo), 1);
        wreg(8'h00, 32'h1);
        check("R5 soft reset writable after reset", 32'(srst), 1);
        wreg(8'h00, 32'h0);
        warm_reset();
        check("R7 unlock sticky", 32'(apo), 1);

        // R6 protection
        prot_cfg = 1'b1;
        warm_reset();
        prot_cfg = 1'b0;
        #0.5;
        rreg(8'h18, v); check("R6 protected status", v, 0);
        wreg(8'h04, 32'h1);
        check("R6 trigger ignored", 32'(req), 0);
        rreg(8'h08, v); check("R6 status stays ready", v, 0);
        wreg(8'h00, 32'h1);
        check("R6 soft reset not frozen", 32'(srst), 1);
        warm_reset();
        #0.5;
        rreg(8'h18, v); check("R6 unprotected after reset", v, 1);

        // R7 cold reset clears unlock
        @(negedge clk); por_n = 1'b0;
        @(negedge clk); por_n = 1'b1;
        check("R7 cold reset clears unlock", 32'(apo), 0);

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule